// File: doc/BRIEF.md
# Received FIS Screening Stage

This block sits on the receive side of a serial storage host port, between the link layer and the logic that keeps the received-frame area and the shadow task-file registers. It takes a device-to-host frame as a stream of 32-bit dwords with start and end markers. Each dword is written into a staging store. When the last dword arrives, the block decides what happens to the frame. It may copy the frame into a committed area that downstream logic reads. It may discard the frame quietly. Or it may reject the frame with an error.

The decision comes one cycle after the end-of-frame beat, together with a handshake answer (good or error) for the link layer and at most one error strobe. The checks cover four things: the CRC result from the link, the frame length for its type, the port-multiplier port field, and whether the addressed device has a command slot in flight. There is one more quiet case, in which a status-carrying frame meets a shadow register whose busy and data-request bits are both clear. Data frames only pass through the CRC check. Their payload is not stored, because moving it is handled elsewhere.

Top module: `rfis_screen`

## Requirements
- R1: The committed area, read through `rdIdx`/`rdData`, changes only in the cycle `commitValid` pulses. It then holds every dword of the committed frame at its beat position, starting from 0.
- R2: The type is bits 7:0 of dword 0 and the port field is bits 11:8. These types have a fixed length: 0x34 is 5 dwords, 0x5F is 5, 0xA1 is 2, 0x41 is 7 and 0x58 is 3. Any other length answers error (`respErr`=1), pulses `protoErrStb` and does not commit.
- R3: A type not listed in R2 (and not 0x46) commits when it has 1 to 16 dwords. With more than 16 dwords it is treated as R2's length error.
- R4: If `crcOk` is low on the end beat, the block answers error, pulses `crcErrStb` and does not commit.
- R5: With `fbsEnable` low, a port field that differs from `expectPmp` is answered good, is discarded and pulses `pmpErrStb`.
- R6: With `fbsEnable` high, a port field whose bit in `activePmpMask` is 0 counts as a mismatch and is handled as in R5. A port field whose bit is 1 passes.
- R7: A 0x34 or 0x5F frame that arrives while `shadowBsy` and `shadowDrq` are both 0 is answered good and discarded, with no strobe. Other types are not affected by those bits.
- R8: When the bit of `slotActiveMask` for the frame's port field is 0, a 0x41 frame pulses `fatalErrStb`, is answered good and is not committed. Any other type is discarded quietly with a good answer.
- R9: The checks are ranked as follows: CRC, then length, then port field, then slot, then the R7 quiet case. Only the outcome of the highest-ranked failing check is seen.
- R10: `respValid` and any outcome pulse last exactly one cycle, starting on the cycle after the end beat. At most one error strobe is high at a time, and `commitValid` implies a good answer.
- R11: A 0x46 data frame of any length is never committed. It is answered good with no strobe when its CRC is good, whatever its port field.
- R12: A start beat always begins a new frame, dropping any unfinished one. Beats that arrive outside a frame, and idle cycles inside one, are ignored.
- R13: After reset all outputs are 0 and the committed area reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Beat present on `inData` |
| inSof | input | 1 | Beat is the first dword of a frame |
| inEof | input | 1 | Beat is the last dword of a frame |
| inData | input | DATA_W | Frame dword |
| crcOk | input | 1 | CRC verdict from link, valid on end beat |
| fbsEnable | input | 1 | Per-frame switching mode (1) or command-based mode (0) |
| expectPmp | input | PMP_W | Single active port in command-based mode |
| activePmpMask | input | 2**PMP_W | Active ports in per-frame switching mode |
| slotActiveMask | input | 2**PMP_W | Per-port: a command slot is in flight |
| shadowBsy | input | 1 | Shadow status busy bit |
| shadowDrq | input | 1 | Shadow status data-request bit |
| rdIdx | input | log2(MAX_DW) | Committed-area read index |
| rdData | output | DATA_W | Committed-area read data |
| respValid | output | 1 | Handshake answer valid |
| respErr | output | 1 | 1 = error answer, 0 = good answer |
| commitValid | output | 1 | Frame copied into committed area |
| commitType | output | 8 | Type of the committed frame |
| commitLen | output | log2(MAX_DW+2) | Dword count of the committed frame |
| crcErrStb | output | 1 | CRC error pulse |
| protoErrStb | output | 1 | Length/protocol error pulse |
| pmpErrStb | output | 1 | Port-field mismatch pulse |
| fatalErrStb | output | 1 | Slot-less DMA setup pulse |

## Verification
The hardest cases to reach are the ones where several checks fail at once and the ranking decides the outcome. Examples are a wrong length together with a bad CRC, a port mismatch together with a dead slot, and an over-long unknown frame that overruns the staging store. The vector table builds these on purpose by choosing the type, the port field, the beat count, the CRC flag and the slot mask together. After each frame the bench reads the committed area back. This shows that a discarded or rejected frame left the previous contents untouched, and a restart test cuts a frame short with a fresh start beat.

// File: rtl/rfis_pkg.sv
package rfis_pkg;

  localparam logic [7:0] TYPE_REG_D2H = 8'h34;
  localparam logic [7:0] TYPE_PIO_SET = 8'h5F;
  localparam logic [7:0] TYPE_DEV_BIT = 8'hA1;
  localparam logic [7:0] TYPE_DMA_SET = 8'h41;
  localparam logic [7:0] TYPE_BIST    = 8'h58;
  localparam logic [7:0] TYPE_DATA    = 8'h46;

  typedef enum logic [2:0] {
    V_COMMIT,
    V_QUIET,
    V_PMP,
    V_FATAL,
    V_CRC,
    V_LEN,
    V_DATA_OK
  } verdict_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startFrame;
    logic storeBeat;
    logic commitNow;
  } dpCtl_t;

  // fixed dword length of a known type, 0 when the type has none
  function automatic logic [7:0] fixedLen(input logic [7:0] fisType);
    case (fisType)
      TYPE_REG_D2H: fixedLen = 8'd5;
      TYPE_PIO_SET: fixedLen = 8'd5;
      TYPE_DEV_BIT: fixedLen = 8'd2;
      TYPE_DMA_SET: fixedLen = 8'd7;
      TYPE_BIST:    fixedLen = 8'd3;
      default:      fixedLen = 8'd0;
    endcase
  endfunction

  function automatic logic carriesStatus(input logic [7:0] fisType);
    carriesStatus = (fisType == TYPE_REG_D2H) || (fisType == TYPE_PIO_SET);
  endfunction

endpackage

// File: rtl/rfis_datapath.sv
module rfis_datapath
  import rfis_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MAX_DW = 16,
  parameter int LEN_W  = 5,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] inData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [LEN_W-1:0]  beatCnt,
  output logic [DATA_W-1:0] hdrReg,
  output logic [DATA_W-1:0] rdData
);

  localparam int unsigned SAT = MAX_DW + 1;

  logic [LEN_W-1:0]  wrPos;
  logic              wrInRange;
  logic [DATA_W-1:0] heldArr [MAX_DW];

  assign wrPos     = ctl.startFrame ? '0 : beatCnt;
  assign wrInRange = int'(wrPos) < MAX_DW;

  // beat counter saturates one past the store depth
  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatCnt <= '0;
      hdrReg  <= '0;
    end else if (ctl.storeBeat) begin
      if (ctl.startFrame) begin
        beatCnt <= LEN_W'(1);
        hdrReg  <= inData;
      end else if (int'(beatCnt) < int'(SAT)) begin
        beatCnt <= beatCnt + LEN_W'(1);
      end
    end
  end

  for (genvar g = 0; g < MAX_DW; g++) begin : gEntry
    logic [DATA_W-1:0] stageQ;
    logic [DATA_W-1:0] heldQ;
    logic              hitNow;

    assign hitNow = ctl.storeBeat && wrInRange && (int'(wrPos) == g);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageQ <= '0;
        heldQ  <= '0;
      end else begin
        if (hitNow) stageQ <= inData;
        if (ctl.commitNow) heldQ <= hitNow ? inData : stageQ;
      end
    end

    assign heldArr[g] = heldQ;
  end

  assign rdData = heldArr[rdIdx];

endmodule

// File: rtl/rfis_control.sv
module rfis_control
  import rfis_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MAX_DW = 16,
  parameter int PMP_W  = 4,
  parameter int LEN_W  = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 inSof,
  input  logic                 inEof,
  input  logic [DATA_W-1:0]    inData,
  input  logic                 crcOk,
  input  logic                 fbsEnable,
  input  logic [PMP_W-1:0]     expectPmp,
  input  logic [2**PMP_W-1:0]  activePmpMask,
  input  logic [2**PMP_W-1:0]  slotActiveMask,
  input  logic                 shadowBsy,
  input  logic                 shadowDrq,
  input  logic [LEN_W-1:0]     beatCnt,
  input  logic [DATA_W-1:0]    hdrReg,
  output dpCtl_t               ctl,
  output logic                 respValid,
  output logic                 respErr,
  output logic                 commitValid,
  output logic [7:0]           commitType,
  output logic [LEN_W-1:0]     commitLen,
  output logic                 crcErrStb,
  output logic                 protoErrStb,
  output logic                 pmpErrStb,
  output logic                 fatalErrStb
);

  localparam int unsigned SAT = MAX_DW + 1;

  logic             inFrame;
  logic             beatTake;
  logic             isEnd;
  logic [DATA_W-1:0] effHdr;
  logic [LEN_W-1:0] effLen;
  logic [7:0]       fisType;
  logic [PMP_W-1:0] pmpField;
  logic [7:0]       needLen;
  logic             isData;
  logic             lenBad;
  logic             pmpBad;
  logic             slotDead;
  logic             statusIdle;
  verdict_t         verdict;

  assign beatTake = inValid && (inSof || inFrame);
  assign isEnd    = beatTake && inEof;

  always_ff @(posedge clk) begin
    if (!rstN)         inFrame <= 1'b0;
    else if (beatTake) inFrame <= !inEof;
  end

  // frame facts as seen with the end beat folded in
  always_comb begin
    effHdr = inSof ? inData : hdrReg;
    if (inSof)                            effLen = LEN_W'(1);
    else if (int'(beatCnt) >= int'(SAT))  effLen = beatCnt;
    else                                  effLen = beatCnt + LEN_W'(1);
  end

  assign fisType  = effHdr[7:0];
  assign pmpField = effHdr[8 +: PMP_W];
  assign needLen  = fixedLen(fisType);
  assign isData   = (fisType == TYPE_DATA);

  always_comb begin
    if (isData)              lenBad = 1'b0;
    else if (needLen != '0)  lenBad = int'(effLen) != int'(needLen);
    else                     lenBad = int'(effLen) > MAX_DW;
  end

  assign pmpBad     = fbsEnable ? !activePmpMask[pmpField] : (pmpField != expectPmp);
  assign slotDead   = !slotActiveMask[pmpField];
  assign statusIdle = carriesStatus(fisType) && !shadowBsy && !shadowDrq;

  // ranked checks: crc, length, port, slot, idle status
  always_comb begin
    if (!crcOk)               verdict = V_CRC;
    else if (isData)          verdict = V_DATA_OK;
    else if (lenBad)          verdict = V_LEN;
    else if (pmpBad)          verdict = V_PMP;
    else if (slotDead)        verdict = (fisType == TYPE_DMA_SET) ? V_FATAL : V_QUIET;
    else if (statusIdle)      verdict = V_QUIET;
    else                      verdict = V_COMMIT;
  end

  assign ctl.startFrame = inValid && inSof;
  assign ctl.storeBeat  = beatTake;
  assign ctl.commitNow  = isEnd && (verdict == V_COMMIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid   <= 1'b0;
      respErr     <= 1'b0;
      commitValid <= 1'b0;
      commitType  <= '0;
      commitLen   <= '0;
      crcErrStb   <= 1'b0;
      protoErrStb <= 1'b0;
      pmpErrStb   <= 1'b0;
      fatalErrStb <= 1'b0;
    end else begin
      respValid   <= isEnd;
      respErr     <= isEnd && (verdict == V_CRC || verdict == V_LEN);
      commitValid <= isEnd && (verdict == V_COMMIT);
      crcErrStb   <= isEnd && (verdict == V_CRC);
      protoErrStb <= isEnd && (verdict == V_LEN);
      pmpErrStb   <= isEnd && (verdict == V_PMP);
      fatalErrStb <= isEnd && (verdict == V_FATAL);
      if (isEnd && verdict == V_COMMIT) begin
        commitType <= fisType;
        commitLen  <= effLen;
      end
    end
  end

endmodule

// File: rtl/rfis_screen.sv
module rfis_screen
  import rfis_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MAX_DW = 16,
  parameter int PMP_W  = 4,
  localparam int NPORT = 2 ** PMP_W,
  localparam int LEN_W = $clog2(MAX_DW + 2),
  localparam int IDX_W = $clog2(MAX_DW)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSof,
  input  logic              inEof,
  input  logic [DATA_W-1:0] inData,
  input  logic              crcOk,
  input  logic              fbsEnable,
  input  logic [PMP_W-1:0]  expectPmp,
  input  logic [NPORT-1:0]  activePmpMask,
  input  logic [NPORT-1:0]  slotActiveMask,
  input  logic              shadowBsy,
  input  logic              shadowDrq,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              respValid,
  output logic              respErr,
  output logic              commitValid,
  output logic [7:0]        commitType,
  output logic [LEN_W-1:0]  commitLen,
  output logic              crcErrStb,
  output logic              protoErrStb,
  output logic              pmpErrStb,
  output logic              fatalErrStb
);

  dpCtl_t            ctl;
  logic [LEN_W-1:0]  beatCnt;
  logic [DATA_W-1:0] hdrReg;

  rfis_control #(
    .DATA_W(DATA_W), .MAX_DW(MAX_DW), .PMP_W(PMP_W), .LEN_W(LEN_W)
  ) u_control (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inSof(inSof), .inEof(inEof), .inData(inData),
    .crcOk(crcOk), .fbsEnable(fbsEnable), .expectPmp(expectPmp),
    .activePmpMask(activePmpMask), .slotActiveMask(slotActiveMask),
    .shadowBsy(shadowBsy), .shadowDrq(shadowDrq),
    .beatCnt(beatCnt), .hdrReg(hdrReg), .ctl(ctl),
    .respValid(respValid), .respErr(respErr),
    .commitValid(commitValid), .commitType(commitType), .commitLen(commitLen),
    .crcErrStb(crcErrStb), .protoErrStb(protoErrStb),
    .pmpErrStb(pmpErrStb), .fatalErrStb(fatalErrStb)
  );

  rfis_datapath #(
    .DATA_W(DATA_W), .MAX_DW(MAX_DW), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .rdIdx(rdIdx),
    .beatCnt(beatCnt), .hdrReg(hdrReg), .rdData(rdData)
  );

endmodule

// File: rtl/rfis_screen_chk.sv
module rfis_screen_chk #(
  parameter int DATA_W = 32,
  parameter int MAX_DW = 16,
  parameter int PMP_W  = 4,
  localparam int LEN_W = $clog2(MAX_DW + 2),
  localparam int IDX_W = $clog2(MAX_DW)
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inEof,
  input logic [IDX_W-1:0]  rdIdx,
  input logic [DATA_W-1:0] rdData,
  input logic              respValid,
  input logic              respErr,
  input logic              commitValid,
  input logic [LEN_W-1:0]  commitLen,
  input logic              crcErrStb,
  input logic              protoErrStb,
  input logic              pmpErrStb,
  input logic              fatalErrStb
);

  assert_held_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!commitValid && $stable(rdIdx)) |-> $stable(rdData));

  assert_proto_is_error_R2: assert property (@(posedge clk) disable iff (!rstN)
    protoErrStb |-> (respValid && respErr && !commitValid));

  assert_crc_is_error_R4: assert property (@(posedge clk) disable iff (!rstN)
    crcErrStb |-> (respValid && respErr && !commitValid));

  assert_pmp_good_answer_R5: assert property (@(posedge clk) disable iff (!rstN)
    pmpErrStb |-> (respValid && !respErr && !commitValid));

  assert_fatal_no_commit_R8: assert property (@(posedge clk) disable iff (!rstN)
    fatalErrStb |-> (respValid && !respErr && !commitValid));

  assert_resp_after_end_R10: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(inValid && inEof));

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({crcErrStb, protoErrStb, pmpErrStb, fatalErrStb}));

  assert_commit_good_R10: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> (respValid && !respErr && commitLen != '0));

  assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

endmodule

bind rfis_screen rfis_screen_chk #(
  .DATA_W(DATA_W), .MAX_DW(MAX_DW), .PMP_W(PMP_W)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inEof(inEof),
  .rdIdx(rdIdx), .rdData(rdData), .respValid(respValid), .respErr(respErr),
  .commitValid(commitValid), .commitLen(commitLen),
  .crcErrStb(crcErrStb), .protoErrStb(protoErrStb),
  .pmpErrStb(pmpErrStb), .fatalErrStb(fatalErrStb)
);

// File: tb/test_rfis_screen.sv
module test_rfis_screen;

  localparam int DATA_W = 32;
  localparam int MAX_DW = 16;
  localparam int PMP_W  = 4;
  localparam int NPORT  = 16;
  localparam int LEN_W  = 5;
  localparam int IDX_W  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic crcOk = 1'b1;
  logic fbsEnable = 1'b0;
  logic [PMP_W-1:0] expectPmp = 4'd2;
  logic [NPORT-1:0] activePmpMask = 16'h0024;
  logic [NPORT-1:0] slotActiveMask = '1;
  logic shadowBsy = 1'b1, shadowDrq = 1'b0;
  logic [IDX_W-1:0] rdIdx = '0;
  logic [DATA_W-1:0] rdData;
  logic respValid, respErr, commitValid;
  logic [7:0] commitType;
  logic [LEN_W-1:0] commitLen;
  logic crcErrStb, protoErrStb, pmpErrStb, fatalErrStb;

  always #5 clk = ~clk;

  rfis_screen #(.DATA_W(DATA_W), .MAX_DW(MAX_DW), .PMP_W(PMP_W)) i_rfis_screen (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inData(inData), .crcOk(crcOk), .fbsEnable(fbsEnable), .expectPmp(expectPmp),
    .activePmpMask(activePmpMask), .slotActiveMask(slotActiveMask),
    .shadowBsy(shadowBsy), .shadowDrq(shadowDrq), .rdIdx(rdIdx), .rdData(rdData),
    .respValid(respValid), .respErr(respErr), .commitValid(commitValid),
    .commitType(commitType), .commitLen(commitLen), .crcErrStb(crcErrStb),
    .protoErrStb(protoErrStb), .pmpErrStb(pmpErrStb), .fatalErrStb(fatalErrStb)
  );

  // stb order: {crc, proto, pmp, fatal}
  typedef struct packed {
    logic [7:0] fType;
    logic [3:0] pmp;
    logic [4:0] len;
    logic       crcGood;
    logic       fbs;
    logic       slotOn;
    logic       bsy;
    logic       drq;
    logic       expErr;
    logic       expCommit;
    logic [3:0] expStb;
  } vec_t;

  localparam int NVEC = 29;
  localparam vec_t VECS [NVEC] = '{
    '{8'h34, 4'd2, 5'd5,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0000}, // R2 reg ok
    '{8'hA1, 4'd2, 5'd2,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0000}, // R2 sdb ok
    '{8'h41, 4'd2, 5'd7,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0000}, // R2 dma ok
    '{8'h5F, 4'd2, 5'd5,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0000}, // R7 pio drq set
    '{8'h34, 4'd2, 5'd5,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000}, // R7 quiet
    '{8'hA1, 4'd2, 5'd2,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0000}, // R7 sdb unaffected
    '{8'h34, 4'd2, 5'd4,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0100}, // R2 short
    '{8'h41, 4'd2, 5'd8,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0100}, // R2 long
    '{8'h34, 4'd2, 5'd5,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1000}, // R4 crc
    '{8'h34, 4'd2, 5'd4,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1000}, // R9 crc over len
    '{8'h34, 4'd3, 5'd5,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0010}, // R5 mismatch
    '{8'h34, 4'd5, 5'd5,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0000}, // R6 active
    '{8'h34, 4'd3, 5'd5,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0010}, // R6 inactive
    '{8'h34, 4'd2, 5'd5,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0000}, // R6 port 2 active
    '{8'h34, 4'd3, 5'd4,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0100}, // R9 len over pmp
    '{8'h41, 4'd2, 5'd7,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0001}, // R8 fatal
    '{8'hA1, 4'd2, 5'd2,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000}, // R8 quiet
    '{8'h41, 4'd3, 5'd7,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0010}, // R9 pmp over slot
    '{8'h77, 4'd2, 5'd16, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0000}, // R3 unknown 16
    '{8'h77, 4'd2, 5'd17, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0100}, // R3 unknown 17
    '{8'h77, 4'd2, 5'd1,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0000}, // R3 unknown 1
    '{8'h58, 4'd2, 5'd3,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0000}, // R2 bist ok
    '{8'h58, 4'd2, 5'd2,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0100}, // R2 bist short
    '{8'h46, 4'd2, 5'd10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000}, // R11 data ok
    '{8'h46, 4'd2, 5'd3,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1000}, // R11 data crc
    '{8'h46, 4'd3, 5'd4,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000}, // R11 data pmp
    '{8'h5F, 4'd2, 5'd5,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000}, // R7 pio quiet
    '{8'h34, 4'd2, 5'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000}, // R9 slot before idle
    '{8'h5F, 4'd2, 5'd5,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'b0000}  // R2 pio ok
  };

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;
  logic [DATA_W-1:0] lastHdr = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wordOf(input int v, input int i, input logic [7:0] t, input logic [3:0] p);
    if (i == 0) return {8'h00, 8'h80, 4'h0, p, t};
    return {8'(v), 8'(i), 16'h5AC3};
  endfunction

  task automatic sendFrame(input int v, input logic [7:0] t, input logic [3:0] p,
                           input int len, input logic good);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inSof   = (i == 0);
      inEof   = (i == len - 1);
      inData  = wordOf(v, i, t, p);
      crcOk   = good;
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0; crcOk = 1'b1;
  endtask

  task automatic checkHeld(input string tag);
    rdIdx = '0;
    #1;
    check(rdData == lastHdr, tag, rdData, lastHdr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    check({respValid, respErr, commitValid, crcErrStb, protoErrStb, pmpErrStb, fatalErrStb} == '0,
          "R13 outputs in reset", {25'd0, respValid, respErr, commitValid, crcErrStb,
          protoErrStb, pmpErrStb, fatalErrStb}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(rdData == '0, "R13 committed area after reset", rdData, 32'd0);
    check(respValid == 1'b0, "R13 no answer after reset", {31'd0, respValid}, 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      vec_t e;
      e = VECS[v];
      fbsEnable      = e.fbs;
      slotActiveMask = e.slotOn ? '1 : '0;
      shadowBsy      = e.bsy;
      shadowDrq      = e.drq;
      sendFrame(v, e.fType, e.pmp, int'(e.len), e.crcGood);
      check(respValid == 1'b1, $sformatf("R10 vec%0d answer", v), {31'd0, respValid}, 32'd1);
      check(respErr == e.expErr, $sformatf("R9 vec%0d answer kind", v),
            {31'd0, respErr}, {31'd0, e.expErr});
      check(commitValid == e.expCommit, $sformatf("R1 vec%0d commit", v),
            {31'd0, commitValid}, {31'd0, e.expCommit});
      check({crcErrStb, protoErrStb, pmpErrStb, fatalErrStb} == e.expStb,
            $sformatf("R9 vec%0d strobes", v),
            {28'd0, crcErrStb, protoErrStb, pmpErrStb, fatalErrStb}, {28'd0, e.expStb});
      if (e.expCommit) begin
        check(commitType == e.fType && commitLen == e.len, $sformatf("R2 vec%0d type/len", v),
              {16'd0, commitType, 3'd0, commitLen}, {16'd0, e.fType, 3'd0, e.len});
        lastHdr = wordOf(v, 0, e.fType, e.pmp);
        for (int i = 0; i < int'(e.len); i++) begin
          rdIdx = IDX_W'(i);
          #1;
          check(rdData == wordOf(v, i, e.fType, e.pmp), $sformatf("R1 vec%0d dword %0d", v, i),
                rdData, wordOf(v, i, e.fType, e.pmp));
        end
      end else begin
        checkHeld($sformatf("R1 vec%0d area untouched", v));
      end
      @(negedge clk);
      check(respValid == 1'b0, $sformatf("R10 vec%0d single pulse", v), {31'd0, respValid}, 32'd0);
    end

    // R12: beats outside a frame are ignored
    fbsEnable = 1'b0; slotActiveMask = '1; shadowBsy = 1'b1; shadowDrq = 1'b0;
    @(negedge clk);
    inValid = 1'b1; inSof = 1'b0; inEof = 1'b1; inData = 32'h0000_0234;
    @(negedge clk);
    inValid = 1'b0; inEof = 1'b0;
    check(respValid == 1'b0, "R12 orphan end beat", {31'd0, respValid}, 32'd0);
    checkHeld("R12 orphan left area");

    // R12: new start beat drops an unfinished frame
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      inValid = 1'b1; inSof = (i == 0); inEof = 1'b0; inData = wordOf(90, i, 8'h34, 4'd2);
    end
    sendFrame(91, 8'hA1, 4'd2, 2, 1'b1);
    check(commitValid && commitLen == 5'd2 && commitType == 8'hA1, "R12 restart commits new frame",
          {16'd0, commitType, 3'd0, commitLen}, {16'd0, 8'hA1, 8'd2});
    lastHdr = wordOf(91, 0, 8'hA1, 4'd2);
    rdIdx = 4'd1; #1;
    check(rdData == wordOf(91, 1, 8'hA1, 4'd2), "R12 restart dword 1", rdData, wordOf(91, 1, 8'hA1, 4'd2));

    // R12: idle cycle in the middle of a frame
    @(negedge clk);
    inValid = 1'b1; inSof = 1'b1; inEof = 1'b0; inData = wordOf(92, 0, 8'h58, 4'd2);
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0;
    @(negedge clk);
    inValid = 1'b1; inData = wordOf(92, 1, 8'h58, 4'd2);
    @(negedge clk);
    inEof = 1'b1; inData = wordOf(92, 2, 8'h58, 4'd2);
    @(negedge clk);
    inValid = 1'b0; inEof = 1'b0;
    check(commitValid && commitLen == 5'd3, "R12 gap inside frame", {31'd0, commitValid}, 32'd1);
    lastHdr = wordOf(92, 0, 8'h58, 4'd2);
    checkHeld("R1 gap frame header");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule